// File: doc/BRIEF.md
# I2C Register-Access Target

This block is an I2C target. It lets an external bus controller read and write an internal bank of 8-bit control registers through a 16-bit register pointer. SCL and SDA are brought into the system clock domain by a synchronizer chain. Every bus event is then decoded from those synchronized copies: START, STOP, and the rising and falling edges of SCL. The block drives SDA only through an open-drain enable. When that enable is high, the line is pulled low.

A transfer begins with a START, followed by an address byte. The address byte holds a 7-bit device address sent MSB first, then a direction bit, where 0 means write and 1 means read.

In a write transfer, the next two bytes set the pointer, high byte first. Each byte after that is written to the register at the pointer, and the pointer then steps by one.

In a read transfer, bytes are fetched from the register bank at the pointer and shifted out MSB first. The transfer continues while the controller acknowledges each byte and ends when it does not. A START or STOP at any moment aborts whatever byte is in flight.

Top module: `i2cRegTarget`

## Requirements
- R1: While reset is asserted, sdaOe, regWrEn and regRdEn are 0 and regAddr is 0x0000.
- R2: The target acknowledges an address byte (SDA held low during the 9th SCL high period) only when its upper 7 bits equal DEV_ADDR (default 0x2A, so bytes 0x54 for write and 0x55 for read). On any other address it never drives SDA, and it produces no strobes until the next START.
- R3: In a write transfer, the first data byte is the pointer high byte and the second is the low byte. Both are acknowledged, and regAddr shows the new 16-bit pointer after the second byte.
- R4: Each later write byte is acknowledged and raises regWrEn for exactly one system clock, with regWrData equal to the byte and regAddr equal to the pointer. The pointer increments by one in the following cycle.
- R5: In a read transfer, each byte is obtained by a one-clock regRdEn pulse at the current regAddr. regRdData must be valid in the cycle after that pulse, and the byte is sent MSB first.
- R6: After each read byte, the pointer increments by one. An ACK from the controller (SDA low on the 9th clock) fetches the next byte. A NACK (SDA high) ends the transfer: no further fetch occurs and SDA stays released until the next START.
- R7: The pointer wraps from 0xFFFF to 0x0000.
- R8: A START or STOP at any point aborts the transfer. A partly received byte is discarded and produces no write strobe, and the pointer keeps its last value.
- R9: A repeated START is accepted in place of a STOP, so a pointer written in one transfer can be followed at once by a read from that pointer.
- R10: sdaOe changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sclIn | input | 1 | Bus clock line as seen at the pad |
| sdaIn | input | 1 | Bus data line as seen at the pad |
| sdaOe | output | 1 | Open-drain enable; 1 pulls SDA low |
| regAddr | output | 16 | Register pointer presented to the bank |
| regWrData | output | 8 | Byte to be written |
| regWrEn | output | 1 | One-clock write strobe |
| regRdEn | output | 1 | One-clock read strobe |
| regRdData | input | 8 | Bank read data, valid the cycle after regRdEn |

## Verification
The hardest situations to reach from the ports are the aborts.

A STOP in the middle of a data byte is produced by holding SCL low after a few data bits, pulling SDA low, raising SCL and then releasing SDA. The bench checks that no write strobe appears and that the pointer is unchanged. A START in the middle of the address byte is produced the same way and must be followed by a normal transfer.

The end of a read is also exercised. After a NACK, a further byte is clocked, and that byte must read as all ones, showing the target has let go of the line. A repeated START between a pointer write and a read checks that the pointer survives the restart.

// File: rtl/i2cRegPkg.sv
package i2cRegPkg;
  localparam int BYTE_W = 8;
  localparam int PTR_W  = 2 * BYTE_W;

  typedef enum logic [3:0] {
    ST_IDLE, ST_ADDR, ST_PHI, ST_PLO, ST_WDAT,
    ST_ACKSET, ST_ACKHOLD, ST_RDAT, ST_RACK, ST_RNEXT
  } stateT;

  typedef struct packed {
    logic shiftIn;
    logic wrByte;
    logic rdFetch;
    logic ptrHiLd;
    logic ptrLoLd;
    logic rdInc;
    logic txShift;
  } ctlStbT;
endpackage

// File: rtl/i2cRegDatapath.sv
module i2cRegDatapath
  import i2cRegPkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  ctlStbT            stb,
  input  logic [BYTE_W-1:0] regRdData,
  output logic              sclRise,
  output logic              sclFall,
  output logic              startDet,
  output logic              stopDet,
  output logic              sdaBit,
  output logic [BYTE_W-1:0] rxByteNow,
  output logic              txBit7,
  output logic              txBit6,
  output logic [PTR_W-1:0]  regAddr,
  output logic [BYTE_W-1:0] regWrData,
  output logic              regWrEn,
  output logic              regRdEn
);
  logic [SYNC_STAGES-1:0] sclSync, sdaSync;
  logic sclS, sdaS, sclD, sdaD;
  logic [BYTE_W-1:0] rxShift, ptrHiStage, txShiftQ;
  logic [PTR_W-1:0]  ptr;
  logic rdPend;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclSync <= '1;
      sdaSync <= '1;
    end else begin
      sclSync <= {sclSync[SYNC_STAGES-2:0], sclIn};
      sdaSync <= {sdaSync[SYNC_STAGES-2:0], sdaIn};
    end
  end

  assign sclS = sclSync[SYNC_STAGES-1];
  assign sdaS = sdaSync[SYNC_STAGES-1];

  assign sclRise   = sclS & ~sclD;
  assign sclFall   = ~sclS & sclD;
  assign startDet  = sclS & sclD & sdaD & ~sdaS;
  assign stopDet   = sclS & sclD & ~sdaD & sdaS;
  assign sdaBit    = sdaS;
  assign rxByteNow = {rxShift[BYTE_W-2:0], sdaS};
  assign txBit7    = txShiftQ[BYTE_W-1];
  assign txBit6    = txShiftQ[BYTE_W-2];
  assign regAddr   = ptr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclD       <= 1'b1;
      sdaD       <= 1'b1;
      rxShift    <= '0;
      ptrHiStage <= '0;
      ptr        <= '0;
      regWrData  <= '0;
      regWrEn    <= 1'b0;
      regRdEn    <= 1'b0;
      rdPend     <= 1'b0;
      txShiftQ   <= '0;
    end else begin
      sclD    <= sclS;
      sdaD    <= sdaS;
      regWrEn <= stb.wrByte;
      regRdEn <= stb.rdFetch;
      rdPend  <= regRdEn;
      if (stb.shiftIn) rxShift <= rxByteNow;
      if (stb.ptrHiLd) ptrHiStage <= rxByteNow;
      if (stb.wrByte)  regWrData <= rxByteNow;
      if (rdPend)
        txShiftQ <= regRdData;
      else if (stb.txShift)
        txShiftQ <= {txShiftQ[BYTE_W-2:0], 1'b0};
      if (stb.ptrLoLd)
        ptr <= {ptrHiStage, rxByteNow};
      else if (regWrEn || stb.rdInc)
        ptr <= ptr + PTR_W'(1);
    end
  end
endmodule

// File: rtl/i2cRegCtrl.sv
module i2cRegCtrl
  import i2cRegPkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h2A
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclRise,
  input  logic              sclFall,
  input  logic              startDet,
  input  logic              stopDet,
  input  logic              sdaBit,
  input  logic [BYTE_W-1:0] rxByteNow,
  input  logic              txBit7,
  input  logic              txBit6,
  output ctlStbT            stb,
  output logic              sdaOe
);
  stateT stateQ, stateNxt, ackNextQ, ackNextNxt;
  logic [3:0] bitCntQ, bitCntNxt;
  logic sdaOeNxt;

  always_comb begin
    stateNxt   = stateQ;
    ackNextNxt = ackNextQ;
    bitCntNxt  = bitCntQ;
    sdaOeNxt   = sdaOe;
    stb        = '0;
    if (startDet) begin
      stateNxt  = ST_ADDR;
      bitCntNxt = 4'd0;
      sdaOeNxt  = 1'b0;
    end else if (stopDet) begin
      stateNxt = ST_IDLE;
      sdaOeNxt = 1'b0;
    end else begin
      case (stateQ)
        ST_ADDR, ST_PHI, ST_PLO, ST_WDAT: begin
          if (sclRise) begin
            stb.shiftIn = 1'b1;
            if (bitCntQ == 4'd7) begin
              bitCntNxt = 4'd0;
              stateNxt  = ST_ACKSET;
              case (stateQ)
                ST_ADDR: begin
                  if (rxByteNow[7:1] != DEV_ADDR) begin
                    stateNxt = ST_IDLE;
                  end else if (rxByteNow[0]) begin
                    ackNextNxt  = ST_RDAT;
                    stb.rdFetch = 1'b1;
                  end else begin
                    ackNextNxt = ST_PHI;
                  end
                end
                ST_PHI: begin
                  stb.ptrHiLd = 1'b1;
                  ackNextNxt  = ST_PLO;
                end
                ST_PLO: begin
                  stb.ptrLoLd = 1'b1;
                  ackNextNxt  = ST_WDAT;
                end
                default: begin
                  stb.wrByte = 1'b1;
                  ackNextNxt = ST_WDAT;
                end
              endcase
            end else begin
              bitCntNxt = bitCntQ + 4'd1;
            end
          end
        end
        ST_ACKSET: begin
          if (sclFall) begin
            sdaOeNxt = 1'b1;
            stateNxt = ST_ACKHOLD;
          end
        end
        ST_ACKHOLD: begin
          if (sclFall) begin
            stateNxt  = ackNextQ;
            bitCntNxt = 4'd0;
            sdaOeNxt  = (ackNextQ == ST_RDAT) ? ~txBit7 : 1'b0;
          end
        end
        ST_RDAT: begin
          if (sclRise) begin
            bitCntNxt = bitCntQ + 4'd1;
            if (bitCntQ == 4'd7) stb.rdInc = 1'b1;
          end else if (sclFall) begin
            if (bitCntQ == 4'd8) begin
              sdaOeNxt = 1'b0;
              stateNxt = ST_RACK;
            end else begin
              stb.txShift = 1'b1;
              sdaOeNxt    = ~txBit6;
            end
          end
        end
        ST_RACK: begin
          if (sclRise) begin
            if (sdaBit) begin
              stateNxt = ST_IDLE;
            end else begin
              stb.rdFetch = 1'b1;
              stateNxt    = ST_RNEXT;
            end
          end
        end
        ST_RNEXT: begin
          if (sclFall) begin
            sdaOeNxt  = ~txBit7;
            bitCntNxt = 4'd0;
            stateNxt  = ST_RDAT;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ   <= ST_IDLE;
      ackNextQ <= ST_IDLE;
      bitCntQ  <= 4'd0;
      sdaOe    <= 1'b0;
    end else begin
      stateQ   <= stateNxt;
      ackNextQ <= ackNextNxt;
      bitCntQ  <= bitCntNxt;
      sdaOe    <= sdaOeNxt;
    end
  end
endmodule

// File: rtl/i2cRegTarget.sv
module i2cRegTarget
  import i2cRegPkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'h2A,
  parameter int         SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  output logic              sdaOe,
  output logic [PTR_W-1:0]  regAddr,
  output logic [BYTE_W-1:0] regWrData,
  output logic              regWrEn,
  output logic              regRdEn,
  input  logic [BYTE_W-1:0] regRdData
);
  ctlStbT stb;
  logic sclRise, sclFall, startDet, stopDet, sdaBit, txBit7, txBit6;
  logic [BYTE_W-1:0] rxByteNow;

  i2cRegDatapath #(.SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn), .stb(stb),
    .regRdData(regRdData), .sclRise(sclRise), .sclFall(sclFall),
    .startDet(startDet), .stopDet(stopDet), .sdaBit(sdaBit),
    .rxByteNow(rxByteNow), .txBit7(txBit7), .txBit6(txBit6),
    .regAddr(regAddr), .regWrData(regWrData), .regWrEn(regWrEn),
    .regRdEn(regRdEn)
  );

  i2cRegCtrl #(.DEV_ADDR(DEV_ADDR)) u_ctrl (
    .clk(clk), .rstN(rstN), .sclRise(sclRise), .sclFall(sclFall),
    .startDet(startDet), .stopDet(stopDet), .sdaBit(sdaBit),
    .rxByteNow(rxByteNow), .txBit7(txBit7), .txBit6(txBit6),
    .stb(stb), .sdaOe(sdaOe)
  );
endmodule

// File: rtl/i2cRegChecker.sv
module i2cRegChecker (
  input logic        clk,
  input logic        rstN,
  input logic        sclIn,
  input logic        sdaOe,
  input logic        regWrEn,
  input logic        regRdEn,
  input logic [15:0] regAddr
);
  a_r1_reset_state: assert property (@(posedge clk)
    !rstN |-> (!sdaOe && !regWrEn && !regRdEn && regAddr == 16'h0000));

  a_r4_wr_single: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn |=> !regWrEn);

  a_r4_ptr_step: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn |=> (regAddr == $past(regAddr) + 16'd1));

  a_r5_rd_single: assert property (@(posedge clk) disable iff (!rstN)
    regRdEn |=> !regRdEn);

  a_r2_no_overlap: assert property (@(posedge clk) disable iff (!rstN)
    !(regWrEn && regRdEn));

  a_r10_oe_scl_low: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sdaOe) |-> !sclIn);
endmodule

bind i2cRegTarget i2cRegChecker u_chk (
  .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaOe(sdaOe),
  .regWrEn(regWrEn), .regRdEn(regRdEn), .regAddr(regAddr)
);

// File: tb/tb_i2cRegTarget.sv
module tb_i2cRegTarget;
  localparam int Q = 8;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rstN = 1'b0;
  logic sclHost = 1'b1, sdaHost = 1'b1;
  logic sdaOe, regWrEn, regRdEn;
  logic [15:0] regAddr;
  logic [7:0]  regWrData;
  logic [7:0]  regRdData = 8'h00;
  wire sdaLine = sdaHost & ~sdaOe;

  i2cRegTarget dut (
    .clk(clk), .rstN(rstN), .sclIn(sclHost), .sdaIn(sdaLine),
    .sdaOe(sdaOe), .regAddr(regAddr), .regWrData(regWrData),
    .regWrEn(regWrEn), .regRdEn(regRdEn), .regRdData(regRdData)
  );

  int total = 0, fails = 0, wrCnt = 0, rdCnt = 0, oeViol = 0;
  logic [15:0] wrA [0:15];
  logic [7:0]  wrD [0:15];
  logic prevOe = 1'b0;
  bit done = 1'b0;

  function automatic logic [7:0] bankVal(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h5A;
  endfunction

  always @(posedge clk) begin
    if (regRdEn) begin
      regRdData <= bankVal(regAddr);
      rdCnt <= rdCnt + 1;
    end
    if (regWrEn) begin
      wrA[wrCnt[3:0]] <= regAddr;
      wrD[wrCnt[3:0]] <= regWrData;
      wrCnt <= wrCnt + 1;
    end
  end

  always @(negedge clk) begin
    if (sdaOe !== prevOe && sclHost) oeViol++;
    prevOe = sdaOe;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic busStart;
    sdaHost = 1'b1; wt(Q);
    sclHost = 1'b1; wt(Q);
    sdaHost = 1'b0; wt(Q);
    sclHost = 1'b0; wt(Q);
  endtask

  task automatic busStop;
    sdaHost = 1'b0; wt(Q);
    sclHost = 1'b1; wt(Q);
    sdaHost = 1'b1; wt(2 * Q);
  endtask

  task automatic clkBit(input logic b, output logic s);
    sdaHost = b; wt(Q);
    sclHost = 1'b1; wt(Q);
    s = sdaLine; wt(Q);
    sclHost = 1'b0; wt(Q);
  endtask

  task automatic sendByte(input logic [7:0] v, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) clkBit(v[i], s);
    clkBit(1'b1, s);
    ack = ~s;
  endtask

  task automatic recvByte(output logic [7:0] v, input logic hostAck);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      clkBit(1'b1, s);
      v[i] = s;
    end
    clkBit(~hostAck, s);
  endtask

  task automatic testReset;
    chk("R1 sdaOe", sdaOe, 0);
    chk("R1 regWrEn", regWrEn, 0);
    chk("R1 regRdEn", regRdEn, 0);
    chk("R1 regAddr", regAddr, 16'h0000);
  endtask

  task automatic testWrite;
    logic a;
    int w0 = wrCnt;
    busStart;
    sendByte(8'h54, a); chk("R2 addr ack", a, 1);
    sendByte(8'h12, a); chk("R3 ptr hi ack", a, 1);
    sendByte(8'h34, a); chk("R3 ptr lo ack", a, 1);
    chk("R3 pointer", regAddr, 16'h1234);
    sendByte(8'hA5, a); chk("R4 data ack", a, 1);
    sendByte(8'h3C, a); chk("R4 data ack", a, 1);
    busStop;
    chk("R4 write count", wrCnt - w0, 2);
    chk("R4 addr0", wrA[w0 % 16], 16'h1234);
    chk("R4 data0", wrD[w0 % 16], 8'hA5);
    chk("R4 addr1", wrA[(w0 + 1) % 16], 16'h1235);
    chk("R4 data1", wrD[(w0 + 1) % 16], 8'h3C);
    chk("R4 pointer after", regAddr, 16'h1236);
  endtask

  task automatic testMismatch;
    logic a;
    int w0 = wrCnt, r0 = rdCnt;
    busStart;
    sendByte(8'h56, a); chk("R2 wrong addr nack", a, 0);
    sendByte(8'h00, a); chk("R2 idle nack", a, 0);
    sendByte(8'h77, a); chk("R2 idle nack", a, 0);
    busStop;
    busStart;
    sendByte(8'h57, a); chk("R2 wrong read addr nack", a, 0);
    busStop;
    chk("R2 no writes", wrCnt - w0, 0);
    chk("R2 no reads", rdCnt - r0, 0);
    chk("R2 pointer kept", regAddr, 16'h1236);
  endtask

  task automatic testRead;
    logic a;
    logic [7:0] v;
    int r0 = rdCnt;
    busStart;
    sendByte(8'h55, a); chk("R5 read addr ack", a, 1);
    recvByte(v, 1'b1); chk("R5 byte0", v, bankVal(16'h1236));
    recvByte(v, 1'b1); chk("R6 byte1 after ack", v, bankVal(16'h1237));
    recvByte(v, 1'b0); chk("R6 byte2", v, bankVal(16'h1238));
    wt(4);
    chk("R6 released after nack", sdaOe, 0);
    recvByte(v, 1'b0); chk("R6 idle after nack", v, 8'hFF);
    busStop;
    chk("R6 fetch count", rdCnt - r0, 3);
    chk("R6 pointer after read", regAddr, 16'h1239);
  endtask

  task automatic testWrap;
    logic a;
    int w0 = wrCnt;
    busStart;
    sendByte(8'h54, a);
    sendByte(8'hFF, a);
    sendByte(8'hFF, a);
    sendByte(8'h11, a);
    sendByte(8'h22, a); chk("R7 ack", a, 1);
    busStop;
    chk("R7 addr top", wrA[w0 % 16], 16'hFFFF);
    chk("R7 data top", wrD[w0 % 16], 8'h11);
    chk("R7 addr wrapped", wrA[(w0 + 1) % 16], 16'h0000);
    chk("R7 data wrapped", wrD[(w0 + 1) % 16], 8'h22);
    chk("R7 pointer", regAddr, 16'h0001);
  endtask

  task automatic testAbort;
    logic a, s;
    int w0 = wrCnt;
    busStart;
    sendByte(8'h54, a);
    sendByte(8'h00, a);
    sendByte(8'h10, a);
    for (int i = 0; i < 5; i++) clkBit(i[0], s);
    busStop;
    chk("R8 stop drops partial byte", wrCnt - w0, 0);
    chk("R8 pointer kept", regAddr, 16'h0010);
    busStart;
    clkBit(1'b0, s); clkBit(1'b1, s); clkBit(1'b0, s);
    busStart;
    sendByte(8'h54, a); chk("R8 restart addr ack", a, 1);
    sendByte(8'h00, a);
    sendByte(8'h20, a);
    sendByte(8'h99, a); chk("R8 data ack", a, 1);
    busStop;
    chk("R8 one write", wrCnt - w0, 1);
    chk("R8 addr", wrA[w0 % 16], 16'h0020);
    chk("R8 data", wrD[w0 % 16], 8'h99);
  endtask

  task automatic testRepStart;
    logic a;
    logic [7:0] v;
    int w0 = wrCnt;
    busStart;
    sendByte(8'h54, a);
    sendByte(8'h00, a);
    sendByte(8'h40, a); chk("R9 ptr ack", a, 1);
    busStart;
    sendByte(8'h55, a); chk("R9 read ack after restart", a, 1);
    recvByte(v, 1'b0); chk("R9 read data", v, bankVal(16'h0040));
    busStop;
    chk("R9 no writes", wrCnt - w0, 0);
    chk("R9 pointer", regAddr, 16'h0041);
  endtask

  initial begin
    wt(5);
    testReset;
    rstN = 1'b1;
    wt(5);
    testWrite;
    testMismatch;
    testRead;
    testWrap;
    testAbort;
    testRepStart;
    chk("R10 sdaOe changes with SCL low", oeViol, 0);
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      total++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule